// File: doc/BRIEF.md
# Elastic Sample FIFO with Programmable Latency

This block carries a continuous stream of sample words from a data-input clock domain into a converter-output clock domain. It does so through an eight-entry ring of storage. A rising edge on the sync input is taken in the write domain. It restarts the write pointer at entry 0 and captures a signed 3-bit offset, then travels to the read domain through a flop synchronizer. There it reloads the read pointer. The distance between the two pointers then sets the latency from input to output in whole samples, and that distance stays fixed for as long as both sides move one word per clock.

The offset is a two's-complement value from -4 to +3. With the default configuration the latency is 5 + offset cycles, so the eight codes map onto eight separate latencies from 1 to 8 samples. Each stored word carries a lap tag. The read side compares it with the lap it expects, and it raises a sticky error when a read would return a word that was not written in that lap. The next sync clears the error.

Top module: `elastic_offset_fifo`

## Requirements
- R1: Every word accepted with `wr_valid` high is stored in an eight-entry ring addressed by 3-bit pointers and appears later, unchanged, on `rd_data`.
- R2: `wr_offset` is a signed two's-complement field (000=0, 001=+1, 010=+2, 011=+3, 100=-4, 101=-3, 110=-2, 111=-1). With both clocks equal and in phase, a word sampled at write edge n appears on `rd_data` after read edge n+5+offset.
- R3: The eight offset codes give eight distinct latencies, one sample apart, covering 1 to 8. The top bit of `wr_offset` changes the latency, so 010 and 110 differ by four samples.
- R4: `wr_offset` is sampled only on a sync rising edge. A change without a sync leaves the latency unchanged.
- R5: A rising edge on `wr_sync` puts the word sampled on that edge into entry 0 and restarts the write pointer from there. The event crosses through a 2-flop synchronizer and an edge detector, and the read pointer is reloaded exactly once, on the third read edge after the sync edge.
- R6: After a sync, with `wr_valid` held high, the latency stays constant and `rd_err` stays 0.
- R7: `rd_data` is 0 from reset until the first sync takes effect. It is also 0 for every read slot that falls before the first word written after that sync.
- R8: `rd_err` goes to 1 when a read finds an entry whose lap tag differs from the expected lap, for example after gaps in `wr_valid`. It stays 1 until the next sync reload clears it.
- R9: During and right after reset, `rd_data` is 0 and `rd_err` is 0.
- R10: A later sync re-applies the current offset. The new latency holds from the fourth read edge after the sync edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain active-low reset |
| wr_valid | input | 1 | Accept `wr_data` on this edge |
| wr_data | input | DATA_W (16) | Sample word in |
| wr_sync | input | 1 | Sync request; its rising edge restarts the pointers |
| wr_offset | input | ADDR_W (3) | Signed latency offset, captured at sync |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain active-low reset |
| rd_data | output | DATA_W (16) | Sample word out, registered |
| rd_err | output | 1 | Sticky slip flag, cleared by sync |

## Verification
The bench builds the block with its defaults: 16-bit words, a 3-bit address (eight entries) and two synchronizer stages. It drives both clock ports from one clock, so each latency is an exact integer that can be predicted. Sweeping all eight offset codes reaches every reload position of the read pointer. That includes the positions where the first reads fall before the new data and must come out as zero, and the full-ring case where an entry is read on the same edge that rewrites it. Gaps in `wr_valid` exercise the lap-tag check, and later syncs exercise the clearing of the error and the change to a new latency.

// File: rtl/efifo_pkg.sv
package efifo_pkg;

    // Read-side progress after reset and after each sync reload
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,   // no sync seen yet, output forced to zero
        RD_PRIME = 2'd1,   // stepping over entries older than the sync
        RD_RUN   = 2'd2    // streaming entries written since the sync
    } rd_phase_e;

endpackage

// File: rtl/efifo_wr_side.sv
module efifo_wr_side #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    input  logic              sync_in,
    input  logic [ADDR_W-1:0] offset,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W:0]   rd_word,
    output logic              sync_tog,
    output logic [ADDR_W-1:0] cfg_offset
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] wptr;
        logic              lap;
        logic              sync_prev;
        logic              tog;
        logic [ADDR_W-1:0] cfg;
    } wr_state_t;

    wr_state_t q, d;
    logic              sync_edge;
    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic              wlap;
    logic [DATA_W:0]   mem_q [DEPTH];

    always_comb begin
        d         = q;
        sync_edge = sync_in & ~q.sync_prev;
        d.sync_prev = sync_in;
        // a sync edge restarts numbering: this edge's word lands in entry 0, lap 0
        waddr = sync_edge ? '0 : q.wptr;
        wlap  = sync_edge ? 1'b0 : q.lap;
        we    = valid;
        if (sync_edge) begin
            d.tog = ~q.tog;
            d.cfg = offset;
        end
        if (valid) begin
            d.wptr = waddr + 1'b1;
            d.lap  = (waddr == LAST) ? ~wlap : wlap;
        end else begin
            d.wptr = waddr;
            d.lap  = wlap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // ring storage: lap tag in the top bit, sample below
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= {wlap, data};
    end

    assign rd_word    = mem_q[rd_addr];
    assign sync_tog   = q.tog;
    assign cfg_offset = q.cfg;

    // R4: the captured offset moves only on a sync edge
    assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_edge |=> $stable(q.cfg));

    // R5: without a write or a sync the write pointer stands still
    assert_wptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !sync_edge) |=> $stable(q.wptr));

endmodule

// File: rtl/efifo_sync_pulse.sv
module efifo_sync_pulse #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic pulse
);
    logic [STAGES:0] sh_q, sh_d;

    // STAGES synchronizing flops followed by one history flop for edge detection
    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign sh_d[0] = tog_in;
        end else begin : g_link
            assign sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign pulse = sh_q[STAGES] ^ sh_q[STAGES-1];

    // R5: one toggle yields a single-cycle reload request
    assert_single_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/efifo_rd_side.sv
module efifo_rd_side
    import efifo_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 3,
    parameter int HANDOFF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic [ADDR_W-1:0] cfg_offset,
    input  logic [DATA_W:0]   rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] data_out,
    output logic              err_out
);
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int BASE_LAT = DEPTH / 2 + 1;
    localparam int RB_INT   = HANDOFF - BASE_LAT + DEPTH;
    localparam logic [ADDR_W-1:0] RELOAD_BASE = ADDR_W'(RB_INT);
    localparam logic [ADDR_W-1:0] LAST        = ADDR_W'(DEPTH - 1);
    localparam logic [ADDR_W:0]   HANDOFF_W   = (ADDR_W+1)'(HANDOFF);

    typedef struct packed {
        rd_phase_e         phase;
        logic [ADDR_W-1:0] rptr;
        logic              lap;
        logic              err;
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t q, d;
    logic [ADDR_W-1:0] reload_val;
    logic              prime;
    logic              tag;

    // latency = BASE_LAT + offset; offset subtracts modulo the ring size
    assign reload_val = RELOAD_BASE - cfg_offset;
    assign prime      = ({1'b0, reload_val} >= HANDOFF_W);
    assign tag        = rd_word[DATA_W];

    always_comb begin
        d = q;
        if (reload) begin
            d.rptr  = reload_val;
            d.lap   = 1'b0;
            d.err   = 1'b0;
            d.data  = '0;
            d.phase = prime ? RD_PRIME : RD_RUN;
        end else begin
            case (q.phase)
                RD_PRIME: begin
                    d.data = '0;
                    d.rptr = q.rptr + 1'b1;
                    if (q.rptr == LAST) d.phase = RD_RUN;
                end
                RD_RUN: begin
                    d.data = rd_word[DATA_W-1:0];
                    d.rptr = q.rptr + 1'b1;
                    if (q.rptr == LAST) d.lap = ~q.lap;
                    if (tag != q.lap) d.err = 1'b1;
                end
                default: d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: RD_IDLE, default: '0};
        else        q <= d;
    end

    assign rd_addr  = q.rptr;
    assign data_out = q.data;
    assign err_out  = q.err;

    // R6: once started, the read pointer advances every cycle between reloads
    assert_rptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase != RD_IDLE && !reload) |=> (q.rptr == ADDR_W'($past(q.rptr) + 1'b1)));

    // R7: no data leaves before the first sync
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == RD_IDLE) |-> (q.data == '0));

    // R7: entries older than the sync are never presented
    assert_prime_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == RD_PRIME) |=> (q.data == '0));

    // R8: the slip flag holds until a reload
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.err && !reload) |=> q.err);

    // R8: a reload always clears the slip flag
    assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !q.err);

endmodule

// File: rtl/elastic_offset_fifo.sv
module elastic_offset_fifo #(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_sync,
    input  logic [ADDR_W-1:0] wr_offset,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err
);
    // write edges from the sync edge to the first read edge after reload
    localparam int HANDOFF = SYNC_STAGES + 2;

    logic              sync_tog;
    logic              reload;
    logic [ADDR_W-1:0] cfg_offset;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W:0]   rd_word;

    efifo_wr_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wr (
        .clk        (wr_clk),
        .rst_n      (wr_rst_n),
        .valid      (wr_valid),
        .data       (wr_data),
        .sync_in    (wr_sync),
        .offset     (wr_offset),
        .rd_addr    (rd_addr),
        .rd_word    (rd_word),
        .sync_tog   (sync_tog),
        .cfg_offset (cfg_offset)
    );

    efifo_sync_pulse #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (rd_clk),
        .rst_n  (rd_rst_n),
        .tog_in (sync_tog),
        .pulse  (reload)
    );

    efifo_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .HANDOFF(HANDOFF)) u_rd (
        .clk        (rd_clk),
        .rst_n      (rd_rst_n),
        .reload     (reload),
        .cfg_offset (cfg_offset),
        .rd_word    (rd_word),
        .rd_addr    (rd_addr),
        .data_out   (rd_data),
        .err_out    (rd_err)
    );

endmodule

// File: tb/tb_elastic_offset_fifo.sv
module tb_elastic_offset_fifo;

    logic        clk = 1'b0;
    logic        wr_rst_n, rd_rst_n, wr_valid, wr_sync, rd_err;
    logic [15:0] wr_data, rd_data;
    logic [2:0]  wr_offset;

    always #4 clk = ~clk;   // 125 MHz, both domains

    elastic_offset_fifo dut (
        .wr_clk(clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_sync(wr_sync), .wr_offset(wr_offset),
        .rd_clk(clk), .rd_rst_n(rd_rst_n), .rd_data(rd_data), .rd_err(rd_err)
    );

    int ecount = 0;
    always @(posedge clk) ecount <= ecount + 1;

    int checks = 0, fails = 0, sync_at = 1 << 20, cur_lat = 5, seen = 0;
    bit done = 1'b0;

    function automatic logic [15:0] sample_of(input int n);
        return 16'(n * 40503) ^ 16'h3c3c;
    endfunction

    function automatic int lat_of(input logic [2:0] c);
        return 5 + int'($signed(c));
    endfunction

    task automatic tick(input bit do_sync);
        @(negedge clk);
        wr_data = sample_of(ecount + 1);
        wr_sync = do_sync;
        if (do_sync) sync_at = ecount + 1;
    endtask

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at edge %0d: actual=%h expected=%h", req, ecount, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at edge %0d: actual=%0d expected=%0d", req, ecount, act, exp);
        end
    endtask

    task automatic check_stream(input string req);
        logic [15:0] exp;
        if (ecount - cur_lat >= sync_at) exp = sample_of(ecount - cur_lat);
        else                             exp = '0;
        check16(req, rd_data, exp);
    endtask

    initial begin
        logic [2:0] codes [8];
        codes = '{3'b000, 3'b010, 3'b110, 3'b001, 3'b101, 3'b111, 3'b011, 3'b100};
        wr_rst_n = 0; rd_rst_n = 0; wr_valid = 1; wr_sync = 0; wr_offset = 3'b000;
        wr_data = '0;
        repeat (3) tick(1'b0);
        check16("R9 reset data", rd_data, 16'h0);
        check_int("R9 reset err", int'(rd_err), 0);
        tick(1'b0);
        wr_rst_n = 1; rd_rst_n = 1;
        repeat (8) begin
            tick(1'b0);
            check16("R7 before first sync", rd_data, 16'h0);
        end
        check_int("R9 err after reset", int'(rd_err), 0);

        // sweep every offset code; R2 latency, R3 distinctness, R5 handoff, R6 steadiness
        for (int idx = 0; idx < 8; idx++) begin
            wr_offset = codes[idx];
            tick(1'b1);
            for (int k = 0; k < 4; k++) begin
                tick(1'b0);
                if (idx == 0) check16("R7 during first handoff", rd_data, 16'h0);
            end
            cur_lat = lat_of(codes[idx]);
            for (int k = 0; k < 16; k++) begin
                tick(1'b0);
                check_stream((ecount - cur_lat >= sync_at) ? "R2 latency" : "R7 primed zero");
                if (k == 12) begin
                    int meas = 0;
                    for (int j = 1; j <= 8; j++)
                        if (sample_of(ecount - j) == rd_data) meas = j;
                    check_int("R3 measured latency", meas, cur_lat);
                    seen |= (1 << meas);
                end
            end
            check_int("R6 no slip", int'(rd_err), 0);
            if (idx == 2) begin
                wr_offset = ~codes[idx];
                for (int k = 0; k < 10; k++) begin
                    tick(1'b0);
                    check_stream("R4 offset ignored without sync");
                end
            end
        end
        check_int("R3 eight distinct latencies", seen, 32'h1FE);
        check16("R1 data carried", rd_data, sample_of(ecount - cur_lat));

        // R8: a gap in writes lets the read side catch stale entries
        wr_valid = 0;
        tick(1'b0);
        tick(1'b0);
        wr_valid = 1;
        repeat (12) tick(1'b0);
        check_int("R8 slip flagged", int'(rd_err), 1);
        repeat (5) tick(1'b0);
        check_int("R8 slip sticky", int'(rd_err), 1);

        // R10: resync with a new offset clears the flag and sets the new latency
        wr_offset = 3'b001;
        tick(1'b1);
        repeat (4) tick(1'b0);
        check_int("R8 cleared by sync", int'(rd_err), 0);
        cur_lat = lat_of(3'b001);
        for (int k = 0; k < 16; k++) begin
            tick(1'b0);
            check_stream("R10 resync latency");
        end
        check_int("R10 no slip after resync", int'(rd_err), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule